// File: doc/BRIEF.md
# External DMA Request Grant Controller

This block accepts active-low transfer requests from several external DMA devices and answers each with an active-low grant strobe that frames one data word. The request lines can change at any time relative to the core clock. Each line therefore passes through a synchronizer, and only a high-to-low transition counts as a new request. Each channel keeps a small count of requests that have not yet been served. This lets a device issue requests back to back at the full clock rate and receive one grant per cycle.

A fixed-priority arbiter picks the channel that is served next. By default channel 0 wins. The requester controls how long a grant lasts. If its line is still low just before the grant starts, the grant becomes a wait-state grant and holds until the line rises again. Otherwise the grant lasts one cycle. A bus-ownership input tells the block whether it already holds the external bus. When it does not, one turnaround cycle is inserted before the grant.

Top module: `ext_dma_grant`

## Requirements
- R1: During and after a synchronous active-high reset, every `gnt_n` bit is 1 and every `ovf` bit is 0. No grant follows reset until a new request edge arrives.
- R2: Only a high-to-low transition of `req_n[i]` creates a request. A line held low for any length of time produces exactly one grant.
- R3: Each channel stores up to `MAX_PEND` (7 by default) ungranted requests. Every stored request later receives its own grant.
- R4: If `req_n[i]` changes between clock edges, the bus is owned and nothing else is pending, the grant is low in the cycle after the fourth rising edge that follows the fall. It is never low earlier than that.
- R5: At most one `gnt_n` bit is low at a time. Among channels with stored requests, the lowest index is granted first.
- R6: A grant whose request line was already high in the cycle before it starts lasts exactly one cycle. Each completed grant consumes one stored request of its channel.
- R7: If the synchronized request is still low in the cycle before the grant starts, the grant stays low until the release is seen. `gnt_n` rises after the third rising edge that follows the rise of `req_n`.
- R8: When `bus_own` is 0 at the moment a grant would start, exactly one extra cycle passes before the grant goes low.
- R9: A request edge that arrives while its channel already holds `MAX_PEND` requests is dropped. That channel's `ovf` bit then goes to 1 and stays at 1 until reset.
- R10: When a grant completes and another request is eligible, the next grant starts in the very next cycle, with no idle cycle in between. A stored request of the channel just served is not eligible if it is the one being consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | NUM_CH | Asynchronous transfer requests, active low, one per channel |
| bus_own | input | 1 | 1 when the block currently owns the external bus |
| gnt_n | output | NUM_CH | Grant strobes, active low, one per channel |
| ovf | output | NUM_CH | Sticky per-channel flag for dropped requests |

## Verification
The hardest state to reach is a channel whose store is full. Grants drain requests faster than any single requester can pulse, so the store must fill while grants are blocked. The stimulus holds channel 0 low so that the controller sits in a wait-state grant. It then pulses channel 3 nine times, checks the sticky flag, and releases channel 0. A scoreboard then expects exactly seven channel-3 grants, delivered back to back.

// File: rtl/ext_dma_pkg.sv
package ext_dma_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TURN  = 2'd1,
      ST_GRANT = 2'd2,
      ST_WAIT  = 2'd3
   } gst_t;
endpackage

// File: rtl/req_sync_edge.sv
module req_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic req_n_async,
   output logic req_low,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev_n;

   if (STAGES < 2) begin : g_bad_stages
      $error("req_sync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         chain  <= '1;
         prev_n <= 1'b1;
      end else begin
         chain  <= {chain[STAGES-2:0], req_n_async};
         prev_n <= chain[STAGES-1];
      end
   end

   assign req_low = ~chain[STAGES-1];
   assign fall    = prev_n & ~chain[STAGES-1];
endmodule

// File: rtl/pend_counter.sv
module pend_counter #(
   parameter int MAX_PEND = 7,
   parameter int CW       = $clog2(MAX_PEND + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          ovf
);
   localparam logic [CW-1:0] FULL = CW'(MAX_PEND);

   logic full, take;

   if (MAX_PEND < 1) begin : g_bad_depth
      $error("pend_counter: MAX_PEND must be at least 1");
   end

   assign full = (cnt == FULL);
   assign take = inc & (~full | dec);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         cnt <= cnt + CW'(take) - CW'(dec);
         if (inc && full && !dec) ovf <= 1'b1;
      end
   end

   AST_CNT_BOUND:   assert property (@(posedge clk) disable iff (rst) cnt <= FULL);   // R3
   AST_OVF_STICKY:  assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);   // R9
   AST_DEC_PENDING: assert property (@(posedge clk) disable iff (rst) dec |-> cnt != '0); // R6
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N         = 4,
   parameter bit LOW_FIRST = 1'b1,
   parameter int IW        = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   assign found = |req;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end else begin : g_high_first
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end

   AST_PICK_VALID: assert property (@(req) found |-> req[idx]) else ; // R5
endmodule

// File: rtl/ext_dma_grant.sv
module ext_dma_grant
   import ext_dma_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int MAX_PEND    = 7,
   parameter int SYNC_STAGES = 2,
   parameter bit LOW_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_CH-1:0] req_n,
   input  logic              bus_own,
   output logic [NUM_CH-1:0] gnt_n,
   output logic [NUM_CH-1:0] ovf
);
   localparam int CW = $clog2(MAX_PEND + 1);
   localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("ext_dma_grant: NUM_CH must be at least 1");
   end
   if (NUM_CH > (1 << IW)) begin : g_bad_iw
      $error("ext_dma_grant: channel index width too small");
   end

   logic [NUM_CH-1:0] req_low, fall, dec, elig;
   logic [CW-1:0]     cnt [NUM_CH];
   gst_t              state, nxt_state;
   logic [IW-1:0]     cur_ch, nxt_ch, sel;
   logic              found, done;
   logic [NUM_CH-1:0] nxt_gnt_n;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      req_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk        (clk),
         .rst        (rst),
         .req_n_async(req_n[i]),
         .req_low    (req_low[i]),
         .fall       (fall[i])
      );
      pend_counter #(.MAX_PEND(MAX_PEND), .CW(CW)) u_cnt (
         .clk(clk),
         .rst(rst),
         .inc(fall[i]),
         .dec(dec[i]),
         .cnt(cnt[i]),
         .ovf(ovf[i])
      );
   end

   // completion of the grant in flight and eligibility that excludes the word being consumed
   always_comb begin
      done = (state == ST_GRANT) || (state == ST_WAIT && !req_low[cur_ch]);
      for (int i = 0; i < NUM_CH; i++) begin
         dec[i]  = done && (cur_ch == IW'(i));
         elig[i] = cnt[i] > CW'(dec[i]);
      end
   end

   prio_pick #(.N(NUM_CH), .LOW_FIRST(LOW_FIRST), .IW(IW)) u_pick (
      .req  (elig),
      .found(found),
      .idx  (sel)
   );

   always_comb begin
      nxt_state = state;
      nxt_ch    = cur_ch;
      unique case (state)
         ST_IDLE: begin
            if (found) begin
               nxt_ch    = sel;
               nxt_state = !bus_own ? ST_TURN : (req_low[sel] ? ST_WAIT : ST_GRANT);
            end
         end
         ST_TURN: nxt_state = req_low[cur_ch] ? ST_WAIT : ST_GRANT;
         ST_GRANT, ST_WAIT: begin
            if (done) begin
               if (found) begin
                  nxt_ch    = sel;
                  nxt_state = !bus_own ? ST_TURN : (req_low[sel] ? ST_WAIT : ST_GRANT);
               end else begin
                  nxt_state = ST_IDLE;
               end
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
      nxt_gnt_n = '1;
      if (nxt_state == ST_GRANT || nxt_state == ST_WAIT) nxt_gnt_n[nxt_ch] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         cur_ch <= '0;
         gnt_n  <= '1;
      end else begin
         state  <= nxt_state;
         cur_ch <= nxt_ch;
         gnt_n  <= nxt_gnt_n;
      end
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(~gnt_n));   // R5
   AST_TURN_ONCE: assert property (@(posedge clk) disable iff (rst)
      state == ST_TURN |=> (state == ST_GRANT || state == ST_WAIT));                    // R8
   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && req_low[cur_ch]) |=> $stable(gnt_n));                          // R7
   AST_GRANT_HAS_WORK: assert property (@(posedge clk) disable iff (rst)
      (state == ST_GRANT) |-> cnt[cur_ch] != '0);                                         // R6
endmodule

// File: tb/ext_dma_grant_tb.sv
module ext_dma_grant_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] req_n;
   logic       bus_own;
   logic [3:0] gnt_n;
   logic [3:0] ovf;

   int   n_chk  = 0;
   int   n_fail = 0;
   bit   sb_en  = 1'b0;
   bit   ended  = 1'b0;
   logic [1:0] exp_q[$];

   always #5 clk = ~clk;

   ext_dma_grant u_dut (
      .clk(clk), .rst(rst), .req_n(req_n), .bus_own(bus_own),
      .gnt_n(gnt_n), .ovf(ovf)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic expect_gnt(input logic [1:0] ch);
      exp_q.push_back(ch);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: every low grant cycle consumes one expected channel
   always @(negedge clk) begin
      if (!rst && sb_en && gnt_n != 4'hF) begin
         if ($countones(~gnt_n) != 1) begin
            chk(1'b0, "R5 single grant", 32'(gnt_n), 32'hF);
         end else if (exp_q.size() == 0) begin
            chk(1'b0, "R2 unexpected grant", 32'(gnt_n), 32'hF);
         end else begin
            logic [1:0] e;
            logic [3:0] want;
            e    = exp_q.pop_front();
            want = ~(4'b0001 << e);
            chk(gnt_n == want, "R5 scoreboard order", 32'(gnt_n), 32'(want));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      rst = 1'b1; req_n = 4'hF; bus_own = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(gnt_n == 4'hF, "R1 reset gnt", 32'(gnt_n), 32'hF);
      chk(ovf == 4'h0, "R1 reset ovf", 32'(ovf), 32'h0);
      rst = 1'b0;
      sb_en = 1'b1;
      repeat (6) @(negedge clk);
      chk(exp_q.size() == 0, "R1 idle after reset", 32'(exp_q.size()), 0);
      sb_en = 1'b0;

      // R4 / R6: single short pulse on channel 2
      req_n[2] = 1'b0;
      @(negedge clk); req_n[2] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(gnt_n == 4'hF, "R4 not early", 32'(gnt_n), 32'hF);
      @(negedge clk);
      chk(gnt_n == 4'b1011, "R4 latency", 32'(gnt_n), 32'hB);
      @(negedge clk);
      chk(gnt_n == 4'hF, "R6 one cycle grant", 32'(gnt_n), 32'hF);
      repeat (3) @(negedge clk);

      // R7 / R2: held request on channel 1 gives one wait-state grant
      req_n[1] = 1'b0;
      repeat (4) @(negedge clk);
      chk(gnt_n == 4'b1101, "R7 wait grant starts", 32'(gnt_n), 32'hD);
      repeat (6) @(negedge clk);
      chk(gnt_n == 4'b1101, "R7 wait grant held", 32'(gnt_n), 32'hD);
      req_n[1] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(gnt_n == 4'b1101, "R7 still low before release seen", 32'(gnt_n), 32'hD);
      @(negedge clk);
      chk(gnt_n == 4'hF, "R7 release ends grant", 32'(gnt_n), 32'hF);
      sb_en = 1'b1;
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0, "R2 held line counted once", 32'(exp_q.size()), 0);
      sb_en = 1'b0;

      // R5 / R10: all four at once, back to back in priority order
      req_n = 4'h0;
      @(negedge clk); req_n = 4'hF;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      chk(gnt_n == 4'b1110, "R5 ch0 first", 32'(gnt_n), 32'hE);
      @(negedge clk);
      chk(gnt_n == 4'b1101, "R10 ch1 next cycle", 32'(gnt_n), 32'hD);
      @(negedge clk);
      chk(gnt_n == 4'b1011, "R10 ch2 next cycle", 32'(gnt_n), 32'hB);
      @(negedge clk);
      chk(gnt_n == 4'b0111, "R10 ch3 next cycle", 32'(gnt_n), 32'h7);
      @(negedge clk);
      chk(gnt_n == 4'hF, "R6 all served", 32'(gnt_n), 32'hF);
      repeat (3) @(negedge clk);

      // R8: bus not owned inserts one turnaround cycle
      bus_own = 1'b0;
      req_n[1] = 1'b0;
      @(negedge clk); req_n[1] = 1'b1;
      repeat (3) @(negedge clk);
      chk(gnt_n == 4'hF, "R8 turnaround cycle", 32'(gnt_n), 32'hF);
      @(negedge clk);
      chk(gnt_n == 4'b1101, "R8 grant after turn", 32'(gnt_n), 32'hD);
      @(negedge clk);
      chk(gnt_n == 4'hF, "R8 grant one cycle", 32'(gnt_n), 32'hF);
      bus_own = 1'b1;
      repeat (3) @(negedge clk);

      // R3 / R5: interleaved pulses on channels 1 and 3
      sb_en = 1'b1;
      expect_gnt(2'd1); expect_gnt(2'd3); expect_gnt(2'd1); expect_gnt(2'd3); expect_gnt(2'd1);
      for (int k = 0; k < 3; k++) begin
         req_n[1] = 1'b0;
         if (k < 2) req_n[3] = 1'b0;
         @(negedge clk);
         req_n = 4'hF;
         @(negedge clk);
      end
      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R3 all stored requests granted", 32'(exp_q.size()), 0);
      sb_en = 1'b0;

      // R9 / R3: fill channel 3 while channel 0 holds a wait-state grant
      req_n[0] = 1'b0;
      repeat (5) @(negedge clk);
      for (int k = 0; k < 9; k++) begin
         req_n[3] = 1'b0;
         @(negedge clk);
         req_n[3] = 1'b1;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(ovf == 4'b1000, "R9 overflow flag", 32'(ovf), 32'h8);
      chk(gnt_n == 4'b1110, "R7 ch0 blocks others", 32'(gnt_n), 32'hE);
      req_n[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(gnt_n == 4'b1110, "R7 ch0 held until release seen", 32'(gnt_n), 32'hE);
      @(posedge clk);
      sb_en = 1'b1;
      for (int k = 0; k < 7; k++) expect_gnt(2'd3);
      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R3 seven grants after overflow", 32'(exp_q.size()), 0);
      chk(ovf == 4'b1000, "R9 flag sticky", 32'(ovf), 32'h8);
      sb_en = 1'b0;

      // R1: reset clears sticky flag
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(ovf == 4'h0, "R1 reset clears ovf", 32'(ovf), 32'h0);
      chk(gnt_n == 4'hF, "R1 reset grants high", 32'(gnt_n), 32'hF);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule